// File: doc/BRIEF.md
# Flagged Conversion Word Serial Output Port

This block is the device-side read port of a converter that runs from its own oscillator. Each time the conversion engine finishes a result it pulses a done strobe together with the result and the raw condition inputs. The block then frames a 24-bit word. The word holds framing zeros, an overrange flag, a modulator-oscillation flag and the two's-complement result, which is 20 bits wide or 16 bits with zero padding. The block announces the word by pulling its data line low. A host then clocks the word out, MSB first, with its own serial clock.

The serial clock and the active-low chip select are asynchronous to the oscillator. Both are synchronized into the oscillator domain, and their edges drive the shift logic. The data line doubles as a ready indicator, so fixed rules decide what happens to a word that nobody reads:
- A word left unread is withdrawn a fixed number of oscillator cycles before the next result arrives.
- A result that completes during a read is dropped.
- A read aborted by chip select throws its word away.

The oscillation flag is stretched so that it stays set for a number of words after the modulator is reported stable.

Top module: `cvw_serial_out`

## Requirements
- R1: With a 20-bit result, the word sent MSB first is: bit 23 = 0, bit 22 = overrange flag, bit 21 = oscillation flag, bit 20 = 0, bits 19..0 = result.
- R2: With a 16-bit result, bits 23..20 are as in R1, bits 19..16 are zero, and bits 15..0 carry the result.
- R3: The data enable `sdo_oe` is 0 whenever `cs_n` is 1 and 1 whenever `cs_n` is 0.
- R4: While a framed word waits and chip select is low, `sdo` is 0; that level is bit 23. With no word waiting and no read in progress, `sdo` is 1.
- R5: Each falling serial clock edge puts the next bit on `sdo`, and the host samples on rising edges. Once the 24th falling edge has been seen, `sdo` returns to 1 until the next word is framed.
- R6: A done strobe that arrives during a read changes neither the word being shifted nor what follows it. That result is lost, and `sdo` stays 1 after the read.
- R7: If chip select rises during a read, the word is discarded. `sdo` then reads 1 until the next done strobe frames a new word.
- R8: A word that is ready but unread is withdrawn HOLD_CYCLES oscillator cycles before the next expected done strobe, CONV_CYCLES after the previous one, and `sdo` goes to 1. At the next done strobe `sdo` falls to 0 again with the new word.
- R9: The overrange flag in each word equals the overrange input that came with that result.
- R10: The oscillation flag is 1 for any result reported unstable and for the next OSC_HOLD results after that. It is also 1 for the first OSC_HOLD results after reset. After that it is 0.
- R11: A word framed while chip select is high stays ready, and it can be read in full once chip select goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: a result is complete |
| conv_result | input | RES_BITS | Two's-complement result, valid with `conv_done` |
| conv_ovr | input | 1 | Result is overranged, valid with `conv_done` |
| mod_unstable | input | 1 | Modulator reported unstable for this result |
| cs_n | input | 1 | Active-low chip select from the host, asynchronous |
| sclk | input | 1 | Serial clock from the host, asynchronous |
| sdo | output | 1 | Serial data and ready indicator |
| sdo_oe | output | 1 | Drive enable for `sdo` (0 = high impedance) |

## Verification
A wrong read state shows up on `sdo` within one serial clock phase. A stuck ready state keeps the line low after a full 24-bit read. A skipped abort leaves the line low after chip select returns. A missed withdrawal keeps the line low through the HOLD_CYCLES window. A bit index that is off by one shifts every following bit, so a single known word catches it. A broken flag counter shows up only in bits 22 and 21 of the words. For that reason a run of words is read back-to-back, across the reset hold-off and after an unstable result.

// File: rtl/cvw_pkg.sv
// Shared types for the flagged conversion word serial port.
// Assumes: a 24-bit frame and a result field of at most 20 bits.
package cvw_pkg;
    localparam int WORD_BITS  = 24;
    localparam int FIELD_BITS = 20;

    // Read-side states of the output word.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // nothing to offer, line high
        ST_READY = 2'd1,   // word framed, line low
        ST_SHIFT = 2'd2,   // host is clocking the word out
        ST_SENT  = 2'd3    // word fully read, line high
    } rd_state_t;
endpackage

// File: rtl/cvw_sync_edge.sv
// Multi-bit level synchronizer with change detection.
// What it does: brings asynchronous host pins into the oscillator domain and
// flags the cycle in which each synchronized level changed.
// Assumes: each input holds its level for at least STAGES+1 clock cycles.
module cvw_sync_edge #(
    parameter int              N_SIG   = 2,
    parameter int              STAGES  = 2,
    parameter logic [N_SIG-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] async_in,
    output logic [N_SIG-1:0] level,
    output logic [N_SIG-1:0] changed
);
    for (genvar g = 0; g < N_SIG; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              prev;

        // Shift the pin through the synchronizer and keep one delayed copy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[g]}};
                prev  <= RST_VAL[g];
            end else begin
                chain <= {chain[STAGES-2:0], async_in[g]};
                prev  <= chain[STAGES-1];
            end
        end

        assign level[g]   = chain[STAGES-1];
        assign changed[g] = chain[STAGES-1] ^ prev;
    end
endmodule

// File: rtl/cvw_flag_cond.sv
// Oscillation flag stretcher and overrange pass-through.
// What it does: the oscillation flag is set for an unstable result and for the
// next OSC_HOLD results; after reset the first OSC_HOLD results are flagged.
// Assumes: conv_done is a one-cycle strobe.
module cvw_flag_cond #(
    parameter int OSC_HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_done,
    input  logic ovr_in,
    input  logic unstable_in,
    output logic word_ovr,
    output logic word_osc
);
    localparam int CW = $clog2(OSC_HOLD + 1);

    logic [CW-1:0] hold_cnt;

    // Count down the remaining flagged results; reload when unstable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= CW'(OSC_HOLD);
        end else if (conv_done) begin
            if (unstable_in)         hold_cnt <= CW'(OSC_HOLD);
            else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign word_ovr = ovr_in;
    assign word_osc = unstable_in || (hold_cnt != '0);

    AST_OSC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && unstable_in) |=> (hold_cnt == CW'(OSC_HOLD))); // R10
    AST_OSC_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !unstable_in && hold_cnt != '0) |=> (hold_cnt == $past(hold_cnt) - 1'b1)); // R10
endmodule

// File: rtl/cvw_period_timer.sv
// Conversion period timer.
// What it does: counts oscillator cycles since the last done strobe. It raises
// drop_now in the cycle that makes the withdrawal take effect exactly
// HOLD_CYCLES cycles before the next strobe is due.
// Assumes: strobes arrive every CONV_CYCLES cycles and HOLD_CYCLES < CONV_CYCLES - 1.
module cvw_period_timer #(
    parameter int CONV_CYCLES = 400,
    parameter int HOLD_CYCLES = 17
) (
    input  logic clk,
    input  logic rst_n,
    input  logic conv_done,
    output logic drop_now
);
    localparam int TW      = $clog2(CONV_CYCLES + 1);
    localparam int DROP_AT = CONV_CYCLES - HOLD_CYCLES - 1;

    logic [TW-1:0] elapsed;

    // Restart on each strobe and saturate at one full period.
    always_ff @(posedge clk) begin
        if (!rst_n)                               elapsed <= TW'(CONV_CYCLES);
        else if (conv_done)                       elapsed <= '0;
        else if (elapsed != TW'(CONV_CYCLES))     elapsed <= elapsed + 1'b1;
    end

    assign drop_now = (elapsed == TW'(DROP_AT)) && !conv_done;

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        elapsed <= TW'(CONV_CYCLES)); // R8
endmodule

// File: rtl/cvw_shift_ctrl.sv
// Output word register and read sequencer.
// What it does: latches a framed word on each done strobe unless a read is in
// progress, announces it with a low line, and shifts one bit per falling
// serial clock edge. It also handles aborts and withdrawals.
// Assumes: all control inputs are already in the oscillator domain.
module cvw_shift_ctrl
    import cvw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 conv_done,
    input  logic [WORD_BITS-1:0] word_in,
    input  logic                 cs_low,
    input  logic                 cs_rise,
    input  logic                 sclk_rise,
    input  logic                 sclk_fall,
    input  logic                 drop_now,
    output logic                 data_bit
);
    localparam logic [4:0] LAST_BIT = 5'(WORD_BITS - 1);

    rd_state_t            st;
    logic [WORD_BITS-1:0] shreg;
    logic [4:0]           bidx;

    // Read state, word register and bit pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            shreg <= '0;
            bidx  <= LAST_BIT;
        end else begin
            case (st)
                ST_IDLE, ST_SENT: begin
                    if (conv_done) begin
                        st    <= ST_READY;
                        shreg <= word_in;
                    end
                end
                ST_READY: begin
                    if (conv_done) begin
                        shreg <= word_in;
                    end else if (drop_now) begin
                        st <= ST_IDLE;
                    end else if (cs_low && sclk_rise) begin
                        st   <= ST_SHIFT;
                        bidx <= LAST_BIT;
                    end
                end
                ST_SHIFT: begin
                    if (cs_rise) begin
                        st <= ST_IDLE;
                    end else if (sclk_fall) begin
                        if (bidx == '0) st   <= ST_SENT;
                        else            bidx <= bidx - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Line level: low when ready, current bit while shifting, high otherwise.
    always_comb begin
        case (st)
            ST_READY: data_bit = 1'b0;
            ST_SHIFT: data_bit = shreg[bidx];
            default:  data_bit = 1'b1;
        endcase
    end

    AST_READ_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT && conv_done && !cs_rise) |=> (st != ST_READY && $stable(shreg))); // R6
    AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT && cs_rise) |=> (st == ST_IDLE)); // R7
    AST_WORD_END: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT && !cs_rise && sclk_fall && bidx == '0) |=> (st == ST_SENT)); // R5
    AST_EARLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READY && drop_now) |=> (st == ST_IDLE)); // R8
    AST_HOLD_WHILE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READY && !cs_low && !drop_now) |=> (st == ST_READY)); // R11
endmodule

// File: rtl/cvw_serial_out.sv
// Flagged conversion word serial output port (top).
// What it does: frames each completed result with its flags and offers it on a
// serial line that also signals readiness.
// Assumes: RES_BITS is 16 or 20; cs_n and sclk are asynchronous to clk and
// each level lasts at least three clk cycles.
module cvw_serial_out
    import cvw_pkg::*;
#(
    parameter int RES_BITS    = 20,
    parameter int CONV_CYCLES = 400,
    parameter int HOLD_CYCLES = 17,
    parameter int OSC_HOLD    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_done,
    input  logic [RES_BITS-1:0] conv_result,
    input  logic                conv_ovr,
    input  logic                mod_unstable,
    input  logic                cs_n,
    input  logic                sclk,
    output logic                sdo,
    output logic                sdo_oe
);
    localparam int SCK_IDX = 0;
    localparam int CS_IDX  = 1;

    logic [1:0]            pin_lvl;
    logic [1:0]            pin_chg;
    logic                  word_ovr;
    logic                  word_osc;
    logic                  drop_now;
    logic [FIELD_BITS-1:0] field;
    logic [WORD_BITS-1:0]  framed;

    cvw_sync_edge #(
        .N_SIG   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b10)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, sclk}),
        .level    (pin_lvl),
        .changed  (pin_chg)
    );

    cvw_flag_cond #(.OSC_HOLD(OSC_HOLD)) flags_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done   (conv_done),
        .ovr_in      (conv_ovr),
        .unstable_in (mod_unstable),
        .word_ovr    (word_ovr),
        .word_osc    (word_osc)
    );

    cvw_period_timer #(
        .CONV_CYCLES (CONV_CYCLES),
        .HOLD_CYCLES (HOLD_CYCLES)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .drop_now  (drop_now)
    );

    // Result field: full width, or zero-padded above a narrower result.
    if (RES_BITS == FIELD_BITS) begin : g_wide
        assign field = conv_result;
    end else begin : g_narrow
        assign field = {{(FIELD_BITS - RES_BITS){1'b0}}, conv_result};
    end

    assign framed = {1'b0, word_ovr, word_osc, 1'b0, field};

    cvw_shift_ctrl shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .word_in   (framed),
        .cs_low    (!pin_lvl[CS_IDX]),
        .cs_rise   (pin_lvl[CS_IDX] && pin_chg[CS_IDX]),
        .sclk_rise (pin_lvl[SCK_IDX] && pin_chg[SCK_IDX]),
        .sclk_fall (!pin_lvl[SCK_IDX] && pin_chg[SCK_IDX]),
        .drop_now  (drop_now),
        .data_bit  (sdo)
    );

    assign sdo_oe = !cs_n;

    AST_FRAME_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> (!framed[23] && !framed[20])); // R1
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> (RES_BITS == FIELD_BITS || framed[19:16] == 4'd0)); // R2
endmodule

// File: tb/cvw_serial_out_tb_top.sv
// Bench for the flagged conversion word serial port: a table walk of result
// words followed by directed corner-case tests. A 20-bit and a 16-bit
// instance share all inputs.
module cvw_serial_out_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CONV_N     = 400;
    localparam int HOLD_N     = 17;
    localparam int HALF_SCK   = 5;

    // Entry: [22]=unstable, [21]=overrange, [20]=expected osc flag, [19:0]=result
    localparam logic [23:0] VEC [8] = '{
        24'h112345,   // settling after reset: osc flag still set
        24'h3FFFFF,   // overrange
        24'h180000,   // most negative
        24'h17FFFF,   // most positive, last flagged word after reset
        24'h000001,   // flag clear
        24'h5ABCDE,   // unstable: flag set
        24'h355555,   // overrange, still stretched
        24'h10F0F0    // still stretched
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [19:0] conv_result = '0;
    logic        conv_ovr = 1'b0;
    logic        mod_unstable = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdo20, oe20, sdo16, oe16;
    int          n_chk = 0;
    int          n_err = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cvw_serial_out #(.RES_BITS(20), .CONV_CYCLES(CONV_N), .HOLD_CYCLES(HOLD_N)) dut_i (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_result(conv_result),
        .conv_ovr(conv_ovr), .mod_unstable(mod_unstable), .cs_n(cs_n), .sclk(sclk),
        .sdo(sdo20), .sdo_oe(oe20));

    cvw_serial_out #(.RES_BITS(16), .CONV_CYCLES(CONV_N), .HOLD_CYCLES(HOLD_N)) dut16_i (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_result(conv_result[15:0]),
        .conv_ovr(conv_ovr), .mod_unstable(mod_unstable), .cs_n(cs_n), .sclk(sclk),
        .sdo(sdo16), .sdo_oe(oe16));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [19:0] d, input logic ovr, input logic uns);
        conv_done = 1'b1; conv_result = d; conv_ovr = ovr; mod_unstable = uns;
        tick(1);
        conv_done = 1'b0; conv_ovr = 1'b0; mod_unstable = 1'b0;
        tick(1);
    endtask

    // Host read: sample before each rising edge, then a full clock period.
    task automatic read_bits(input int nbits, inout logic [23:0] a20, inout logic [23:0] a16);
        for (int i = 0; i < nbits; i++) begin
            a20 = {a20[22:0], sdo20};
            a16 = {a16[22:0], sdo16};
            sclk = 1'b1; tick(HALF_SCK);
            sclk = 1'b0; tick(HALF_SCK);
        end
    endtask

    function automatic logic [23:0] exp_word(input bit wide, input logic ovr,
                                             input logic osc, input logic [19:0] d);
        if (wide) return {1'b0, ovr, osc, 1'b0, d};
        return {1'b0, ovr, osc, 1'b0, 4'h0, d[15:0]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: run did not complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [23:0] w20, w16;
        // Reset state
        tick(5);
        chk("R3 enable off while deselected", {23'd0, oe20}, 24'd0);
        rst_n = 1'b1;
        tick(2);
        cs_n = 1'b0;
        tick(5);
        chk("R3 enable on while selected", {23'd0, oe20}, 24'd1);
        chk("R4 idle line high after reset", {23'd0, sdo20}, 24'd1);

        // Table walk: frame, ready level, full read, flags, end level
        for (int k = 0; k < 8; k++) begin
            pulse(VEC[k][19:0], VEC[k][21], VEC[k][22]);
            tick(3);
            chk("R4 ready low", {22'd0, sdo16, sdo20}, 24'd0);
            w20 = '0; w16 = '0;
            read_bits(24, w20, w16);
            chk("R1 20-bit word", w20, exp_word(1'b1, VEC[k][21], VEC[k][20], VEC[k][19:0]));
            chk("R2 16-bit word", w16, exp_word(1'b0, VEC[k][21], VEC[k][20], VEC[k][19:0]));
            chk("R9 overrange flag", {23'd0, w20[22]}, {23'd0, VEC[k][21]});
            chk("R10 oscillation flag", {23'd0, w20[21]}, {23'd0, VEC[k][20]});
            tick(3);
            chk("R5 line high after read", {22'd0, sdo16, sdo20}, 24'd3);
        end

        // R6: a result completing mid-read is lost
        pulse(20'h11111, 1'b0, 1'b0);
        tick(3);
        w20 = '0; w16 = '0;
        read_bits(8, w20, w16);
        pulse(20'h22222, 1'b0, 1'b0);
        read_bits(16, w20, w16);
        chk("R6 word unchanged by mid-read result", {4'd0, w20[19:0]}, 24'h011111);
        tick(3);
        chk("R6 mid-read result not offered", {23'd0, sdo20}, 24'd1);

        // R7: chip select rising mid-read discards the word
        pulse(20'h33333, 1'b0, 1'b0);
        tick(3);
        w20 = '0; w16 = '0;
        read_bits(5, w20, w16);
        cs_n = 1'b1; tick(6);
        cs_n = 1'b0; tick(6);
        chk("R7 aborted word discarded", {23'd0, sdo20}, 24'd1);
        pulse(20'h44444, 1'b0, 1'b0);
        tick(3);
        chk("R7 next word ready", {23'd0, sdo20}, 24'd0);
        w20 = '0; w16 = '0;
        read_bits(24, w20, w16);
        chk("R7 next word intact", {4'd0, w20[19:0]}, 24'h044444);

        // R11: word framed while deselected stays ready
        cs_n = 1'b1;
        pulse(20'h55AA5, 1'b0, 1'b0);
        tick(20);
        chk("R3 enable off during wait", {23'd0, oe20}, 24'd0);
        cs_n = 1'b0; tick(5);
        chk("R11 held word ready", {23'd0, sdo20}, 24'd0);
        w20 = '0; w16 = '0;
        read_bits(24, w20, w16);
        chk("R11 held word intact", {4'd0, w20[19:0]}, 24'h055AA5);

        // R8: unread word withdrawn HOLD_N cycles before the next result
        pulse(20'h0BEEF, 1'b0, 1'b0);      // ends one cycle after capture
        tick(CONV_N - HOLD_N - 4);
        chk("R8 still ready before window", {23'd0, sdo20}, 24'd0);
        tick(6);
        chk("R8 withdrawn inside window", {23'd0, sdo20}, 24'd1);
        tick(HOLD_N - 4);                  // next strobe captured CONV_N after last
        pulse(20'h0CAFE, 1'b0, 1'b0);
        tick(2);
        chk("R8 falls again with next word", {23'd0, sdo20}, 24'd0);
        w20 = '0; w16 = '0;
        read_bits(24, w20, w16);
        chk("R8 new word read", {4'd0, w20[19:0]}, 24'h00CAFE);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule